// File: doc/BRIEF.md
# Parallel ATA PIO Cycle Timer

This block times programmed-I/O cycles on a parallel ATA port with two channels, each carrying a master and a slave device. Each of the four devices has its own timing. A device takes a setup count, an active-strobe count and a recovery count. All three are stored as "length minus one" fields, packed into a shared timing word and a shared setup word.

The host raises a request with a device index and a direction. When the block is idle it accepts the request and acknowledges it for one clock. It then runs three phases in order:

- Address setup: the channel select is low and both strobes are high.
- Active: the read or write strobe is low.
- Recovery: both strobes are high again.

After recovery it pulses done. A ready input can stretch the active phase when stretching is enabled. The block also passes the per-channel prefetch and post-write enable bits of a control word to dedicated outputs.

Top module: `ata_pio_timer`

## Requirements
- R1: While reset is held and on the first clock after it is released, rd_n, wr_n and both bits of chsel_n are high, and done and req_ack are low.
- R2: A req_valid seen on a clock edge while idle is accepted on that edge. req_ack is then high for exactly one clock, and that clock is the first clock of the setup phase.
- R3: The setup phase lasts the setup field plus one clocks. During setup the selected channel's chsel_n is low and rd_n and wr_n are high. The field for device i sits at setup_word[(3-i)*2+1:(3-i)*2]. Device i is {channel, device}: 0 is primary master, 1 is primary slave, 2 is secondary master and 3 is secondary slave.
- R4: The active phase lasts the active field plus one clocks. The field for device i sits at timing_word[(3-i)*8+7:(3-i)*8+4]. rd_n is low for req_write=0 and wr_n is low for req_write=1. The two strobes are never low together.
- R5: The recovery phase lasts the recovery field plus one clocks, with both strobes high and chsel_n still low. The field for device i sits at timing_word[(3-i)*8+3:(3-i)*8].
- R6: done is high for exactly one clock: the first clock after recovery ends, when chsel_n has returned to all ones.
- R7: With iordy_en=1, if iordy is low on the edge that ends the last counted active clock, the active phase holds. The phase ends on the first edge that sees iordy high.
- R8: With iordy_en=0, the level of iordy has no effect on the length of the active phase.
- R9: A request raised while a cycle is in progress is ignored. No req_ack is given, and the running cycle keeps its device and timing.
- R10: The timing and setup words are sampled on the edge that accepts a request. Changes to them during a cycle do not alter that cycle.
- R11: During a cycle only chsel_n[req_drive[1]] is low, and dev_sel equals req_drive[0] of the accepted request.
- R12: pri_prefetch_en, pri_postwr_en, sec_prefetch_en and sec_postwr_en follow ctrl_word bits 15, 14, 13 and 12 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request |
| req_drive | input | 2 | Device index {channel, device} |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_ack | output | 1 | One-clock acceptance pulse |
| done | output | 1 | One-clock end-of-cycle pulse |
| timing_word | input | 32 | Packed active/recovery fields, one byte per device |
| setup_word | input | 8 | Packed setup fields, two bits per device |
| ctrl_word | input | 16 | Control word carrying the prefetch/post-write bits |
| iordy | input | 1 | Device ready (low = stretch) |
| iordy_en | input | 1 | Enables stretching by iordy |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| chsel_n | output | 2 | Per-channel select, active low |
| dev_sel | output | 1 | Device select within the channel |
| pri_prefetch_en | output | 1 | Primary channel prefetch enable |
| pri_postwr_en | output | 1 | Primary channel post-write enable |
| sec_prefetch_en | output | 1 | Secondary channel prefetch enable |
| sec_postwr_en | output | 1 | Secondary channel post-write enable |

## Verification
The bench builds the block with its package defaults: four devices, 4-bit active and recovery fields, and 2-bit setup fields. With these widths every field extreme is reachable in a short run. The bench drives zero fields (one-clock phases) and all-ones fields (16-clock active and recovery, 4-clock setup). It gives each of the four devices a distinct pattern, so a misplaced byte or a swapped slot order shows up as a wrong phase length. Ready stretching, requests raised mid-cycle and word changes mid-cycle are run on long-timing devices, so each disturbance lands well inside a running cycle.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;

    localparam int NUM_SLOTS    = 4;
    localparam int SET_W        = 2;
    localparam int ACT_W        = 4;
    localparam int REC_W        = 4;
    localparam int SLOT_W       = ACT_W + REC_W;
    localparam int TIMING_W     = NUM_SLOTS * SLOT_W;
    localparam int SETUP_WORD_W = NUM_SLOTS * SET_W;
    localparam int DRV_W        = $clog2(NUM_SLOTS);
    localparam int NUM_CHAN     = NUM_SLOTS / 2;
    localparam int CTRL_W       = 16;

    localparam int PRI_PF_BIT = 15;
    localparam int PRI_PW_BIT = 14;
    localparam int SEC_PF_BIT = 13;
    localparam int SEC_PW_BIT = 12;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CNT_W = max_of(max_of(ACT_W, REC_W), SET_W);

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SET_W-1:0] setup;
        logic [ACT_W-1:0] act;
        logic [REC_W-1:0] rec;
    } slot_timing_t;

endpackage

// File: rtl/ata_slot_select.sv
module ata_slot_select
    import ata_pio_pkg::*;
(
    input  logic [TIMING_W-1:0]     timing_word,
    input  logic [SETUP_WORD_W-1:0] setup_word,
    input  logic [DRV_W-1:0]        drive,
    output slot_timing_t            slot
);
    logic [ACT_W-1:0] act_a   [NUM_SLOTS];
    logic [REC_W-1:0] rec_a   [NUM_SLOTS];
    logic [SET_W-1:0] setup_a [NUM_SLOTS];

    // Slot 0 lives in the most significant position of each word.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam int BYTE_LSB = (NUM_SLOTS - 1 - i) * SLOT_W;
        localparam int SET_LSB  = (NUM_SLOTS - 1 - i) * SET_W;
        assign act_a[i]   = timing_word[BYTE_LSB + REC_W +: ACT_W];
        assign rec_a[i]   = timing_word[BYTE_LSB +: REC_W];
        assign setup_a[i] = setup_word[SET_LSB +: SET_W];
    end

    always_comb begin
        slot.setup = setup_a[drive];
        slot.act   = act_a[drive];
        slot.rec   = rec_a[drive];
    end
endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
    import ata_pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [DRV_W-1:0] req_drive,
    input  logic             req_write,
    input  slot_timing_t     slot_in,
    input  logic             iordy,
    input  logic             iordy_en,
    output phase_e           phase,
    output logic [DRV_W-1:0] cur_drive,
    output logic             cur_write,
    output logic             req_ack,
    output logic             done
);
    phase_e           state;
    logic [CNT_W-1:0] cnt;
    slot_timing_t     lat;
    logic             stall;

    assign stall = iordy_en && !iordy;
    assign phase = state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= PH_IDLE;
            cnt       <= '0;
            lat       <= '0;
            cur_drive <= '0;
            cur_write <= 1'b0;
            req_ack   <= 1'b0;
            done      <= 1'b0;
        end else begin
            req_ack <= 1'b0;
            done    <= 1'b0;
            unique case (state)
                PH_IDLE: begin
                    if (req_valid) begin
                        lat       <= slot_in;
                        cur_drive <= req_drive;
                        cur_write <= req_write;
                        cnt       <= CNT_W'(slot_in.setup);
                        state     <= PH_SETUP;
                        req_ack   <= 1'b1;
                    end
                end
                PH_SETUP: begin
                    if (cnt == '0) begin
                        cnt   <= CNT_W'(lat.act);
                        state <= PH_ACTIVE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_ACTIVE: begin
                    if (cnt == '0) begin
                        if (!stall) begin
                            cnt   <= CNT_W'(lat.rec);
                            state <= PH_RECOV;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                PH_RECOV: begin
                    if (cnt == '0) begin
                        state <= PH_IDLE;
                        done  <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    AST_ACK_IN_SETUP: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (state == PH_SETUP && $past(state) == PH_IDLE)); // R2
    AST_DONE_AFTER_RECOV: assert property (@(posedge clk) disable iff (rst)
        done |-> (state == PH_IDLE && $past(state) == PH_RECOV)); // R6
    AST_IORDY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state == PH_ACTIVE && cnt == '0 && iordy_en && !iordy) |=> (state == PH_ACTIVE)); // R7
    AST_TIMING_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (state != PH_IDLE && $past(state) != PH_IDLE) |-> ($stable(lat) && $stable(cur_drive))); // R10
    AST_NO_REACCEPT: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != PH_IDLE) |-> !req_ack); // R9
endmodule

// File: rtl/ata_strobe_drv.sv
module ata_strobe_drv
    import ata_pio_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  phase_e              phase,
    input  logic [DRV_W-1:0]    cur_drive,
    input  logic                cur_write,
    output logic                rd_n,
    output logic                wr_n,
    output logic [NUM_CHAN-1:0] chsel_n,
    output logic                dev_sel
);
    logic busy;
    logic active;

    assign busy    = (phase != PH_IDLE);
    assign active  = (phase == PH_ACTIVE);
    assign rd_n    = !(active && !cur_write);
    assign wr_n    = !(active && cur_write);
    assign dev_sel = cur_drive[0];

    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        assign chsel_n[c] = !(busy && (int'(cur_drive >> 1) == c));
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (rd_n || wr_n)); // R4
    AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~chsel_n)); // R11
    AST_STROBE_INSIDE: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> (chsel_n != '1)); // R3
endmodule

// File: rtl/ata_pio_timer.sv
module ata_pio_timer
    import ata_pio_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    req_valid,
    input  logic [DRV_W-1:0]        req_drive,
    input  logic                    req_write,
    output logic                    req_ack,
    output logic                    done,
    input  logic [TIMING_W-1:0]     timing_word,
    input  logic [SETUP_WORD_W-1:0] setup_word,
    input  logic [CTRL_W-1:0]       ctrl_word,
    input  logic                    iordy,
    input  logic                    iordy_en,
    output logic                    rd_n,
    output logic                    wr_n,
    output logic [NUM_CHAN-1:0]     chsel_n,
    output logic                    dev_sel,
    output logic                    pri_prefetch_en,
    output logic                    pri_postwr_en,
    output logic                    sec_prefetch_en,
    output logic                    sec_postwr_en
);
    slot_timing_t     slot_sel;
    phase_e           phase;
    logic [DRV_W-1:0] cur_drive;
    logic             cur_write;

    ata_slot_select u_sel (
        .timing_word (timing_word),
        .setup_word  (setup_word),
        .drive       (req_drive),
        .slot        (slot_sel)
    );

    ata_phase_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_drive (req_drive),
        .req_write (req_write),
        .slot_in   (slot_sel),
        .iordy     (iordy),
        .iordy_en  (iordy_en),
        .phase     (phase),
        .cur_drive (cur_drive),
        .cur_write (cur_write),
        .req_ack   (req_ack),
        .done      (done)
    );

    ata_strobe_drv u_drv (
        .clk       (clk),
        .rst       (rst),
        .phase     (phase),
        .cur_drive (cur_drive),
        .cur_write (cur_write),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .chsel_n   (chsel_n),
        .dev_sel   (dev_sel)
    );

    assign pri_prefetch_en = ctrl_word[PRI_PF_BIT];
    assign pri_postwr_en   = ctrl_word[PRI_PW_BIT];
    assign sec_prefetch_en = ctrl_word[SEC_PF_BIT];
    assign sec_postwr_en   = ctrl_word[SEC_PW_BIT];

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> (rd_n && wr_n && chsel_n == '1 && !done && !req_ack)); // R1
endmodule

// File: tb/ata_pio_timer_test.sv
module ata_pio_timer_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_drive;
    logic        req_write;
    logic        req_ack;
    logic        done;
    logic [31:0] timing_word;
    logic [7:0]  setup_word;
    logic [15:0] ctrl_word;
    logic        iordy;
    logic        iordy_en;
    logic        rd_n;
    logic        wr_n;
    logic [1:0]  chsel_n;
    logic        dev_sel;
    logic        pri_prefetch_en;
    logic        pri_postwr_en;
    logic        sec_prefetch_en;
    logic        sec_postwr_en;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ata_pio_timer uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_drive(req_drive),
        .req_write(req_write), .req_ack(req_ack), .done(done),
        .timing_word(timing_word), .setup_word(setup_word), .ctrl_word(ctrl_word),
        .iordy(iordy), .iordy_en(iordy_en), .rd_n(rd_n), .wr_n(wr_n),
        .chsel_n(chsel_n), .dev_sel(dev_sel),
        .pri_prefetch_en(pri_prefetch_en), .pri_postwr_en(pri_postwr_en),
        .sec_prefetch_en(sec_prefetch_en), .sec_postwr_en(sec_postwr_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Field placement computed from the requirements: slot i at byte (3-i), setup at pair (3-i).
    task automatic set_slot(input int i, input int s, input int a, input int r);
        int sh = (3 - i) * 8;
        int ss = (3 - i) * 2;
        timing_word = (timing_word & ~(32'hFF << sh)) | (32'((a << 4) | r) << sh);
        setup_word  = (setup_word & ~(8'h3 << ss)) | (8'(s) << ss);
    endtask

    task automatic run_cycle(input int drv, input bit wr, input int exp_s, input int exp_a,
                             input int exp_r, input bit en, input bit lo, input int release_at,
                             input bit disturb, input string tag);
        int s = 0, a = 0, r = 0, guard = 0;
        int bad_strobe = 0, bad_sel = 0, extra_ack = 0;
        logic [31:0] tw_save = timing_word;
        logic [7:0]  sw_save = setup_word;
        logic [1:0]  exp_chsel = ~(2'b01 << drv[1]);
        iordy_en = en;
        iordy    = !lo;
        @(negedge clk);
        req_valid = 1'b1; req_drive = 2'(drv); req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ack == 1'b1, {tag, " R2 ack"}, int'(req_ack), 1);
        if (disturb) begin
            timing_word = ~timing_word;
            setup_word  = ~setup_word;
            req_valid   = 1'b1;
            req_drive   = 2'(drv ^ 3);
        end
        while (chsel_n != 2'b11 && guard < 300) begin
            if (guard > 0 && req_ack) extra_ack++;
            if (chsel_n != exp_chsel || dev_sel != drv[0]) bad_sel++;
            if ((!rd_n && wr) || (!wr_n && !wr)) bad_strobe++;
            if (!rd_n || !wr_n) begin
                a++;
                if (release_at > 0 && a == release_at) iordy = 1'b1;
            end else if (a == 0) s++;
            else r++;
            if (disturb && guard == 2) req_valid = 1'b0;
            guard++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(s == exp_s, {tag, " R3 setup length"}, s, exp_s);
        chk(a == exp_a, {tag, " R4 active length"}, a, exp_a);
        chk(r == exp_r, {tag, " R5 recovery length"}, r, exp_r);
        chk(bad_strobe == 0, {tag, " R4 strobe direction"}, bad_strobe, 0);
        chk(bad_sel == 0, {tag, " R11 channel/device select"}, bad_sel, 0);
        chk(done == 1'b1, {tag, " R6 done at end"}, int'(done), 1);
        if (disturb) chk(extra_ack == 0, {tag, " R9 mid-cycle request ignored"}, extra_ack, 0);
        timing_word = tw_save;
        setup_word  = sw_save;
        iordy       = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, {tag, " R6 done one clock"}, int'(done), 0);
        chk(chsel_n == 2'b11 && req_ack == 1'b0, {tag, " R9 no new cycle"}, int'(chsel_n), 3);
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b1; req_drive = 2'd0; req_write = 1'b0;
        timing_word = '0; setup_word = '0; ctrl_word = '0; iordy = 1'b1; iordy_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(rd_n && wr_n && chsel_n == 2'b11 && !done && !req_ack, "R1 during reset", int'(chsel_n), 3);
        req_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk(rd_n && wr_n && chsel_n == 2'b11 && !done && !req_ack, "R1 after reset", int'(chsel_n), 3);
    endtask

    task automatic t_slots();
        set_slot(0, 1, 3, 2);
        set_slot(1, 0, 0, 0);
        set_slot(2, 3, 15, 15);
        set_slot(3, 2, 5, 9);
        run_cycle(0, 1'b0, 2, 4, 3, 1'b0, 1'b0, 0, 1'b0, "pri master read");
        run_cycle(1, 1'b1, 1, 1, 1, 1'b0, 1'b0, 0, 1'b0, "pri slave write");
        run_cycle(2, 1'b0, 4, 16, 16, 1'b0, 1'b0, 0, 1'b0, "sec master read max");
        run_cycle(3, 1'b1, 3, 6, 10, 1'b0, 1'b0, 0, 1'b0, "sec slave write");
    endtask

    task automatic t_iordy();
        // R7: ready low through the counted clocks, released after 3 extra clocks.
        run_cycle(3, 1'b0, 3, 9, 10, 1'b1, 1'b1, 9, 1'b0, "R7 stretch");
        // R8: ready low for the whole cycle but stretching disabled.
        run_cycle(0, 1'b1, 2, 4, 3, 1'b0, 1'b1, 0, 1'b0, "R8 ready ignored");
    endtask

    task automatic t_disturb();
        // R9 and R10: other-device request and inverted words during a long cycle.
        run_cycle(2, 1'b1, 4, 16, 16, 1'b0, 1'b0, 0, 1'b1, "R10 words frozen");
    endtask

    task automatic t_ctrl();
        ctrl_word = 16'hA000;
        #1;
        chk(pri_prefetch_en && !pri_postwr_en && sec_prefetch_en && !sec_postwr_en,
            "R12 bits 15/13", int'({pri_prefetch_en, pri_postwr_en, sec_prefetch_en, sec_postwr_en}), 10);
        ctrl_word = 16'h5FFF & 16'h5000;
        #1;
        chk(!pri_prefetch_en && pri_postwr_en && !sec_prefetch_en && sec_postwr_en,
            "R12 bits 14/12", int'({pri_prefetch_en, pri_postwr_en, sec_prefetch_en, sec_postwr_en}), 5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_slots();
        t_iordy();
        t_disturb();
        t_ctrl();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule